// File: doc/BRIEF.md
# Break-Sync Bus Access Scheduler

This block decides the moment at which a node may begin a frame on a shared serial bus that runs at a single bit rate and has no bitwise arbitration. Each node is set up with its own permit delay, and the delays differ enough that nodes do not collide. The scheduler counts the bit times during which the receive line stays high. It reports an idle bus once that count reaches a configured wait. It grants a pending frame to the transmitter at this node's permit point.

A frame may become pending after the permit point has passed. In that case the scheduler waits until the idle count goes beyond a configured maximum. It then pulls the line low for ten bit times, a break character, to wake every node. After the break the usual permit rule applies again. The scheduler also detects break characters sent by other nodes, and software can ask for a break at any time.

The byte serializer sits beside this block. It receives a one-cycle grant pulse, and while it sends the frame its own output returns on the receive line. Timing counts step at bit-period boundaries that line up with the most recent falling edge seen on the receive line.

Top module: `bs_sched`

## Requirements
- R1: After reset, `tx_go`, `drive_en`, `line_low`, `bus_idle` and `brk_flag` are all low. The configuration takes these reset values: idle wait 10, permit 20, maximum idle 200 and lead 1 bit times.
- R2: `bus_idle` rises on the bit boundary at which rx has been high for the configured idle-wait number of bit times. It drops in the cycle after rx is first seen low.
- R3: If `frame_pending` is high when the idle count reaches the permit length, `tx_go` pulses for exactly one cycle. With lead 0 the pulse falls on that boundary. With lead k it falls k bit times later.
- R4: With a non-zero lead, `drive_en` is high from the permit boundary up to, but not including, the `tx_go` cycle. With lead 0, `drive_en` stays low for a granted frame.
- R5: A frame that was not pending at the permit point gets no grant. It is served once the idle count is greater than the maximum idle length. Then `line_low` and `drive_en` rise together, in the cycle after the scheduler sees both conditions, with no lead time.
- R6: A break holds `line_low` for exactly 10 bit times, measured from the first low sample of rx. The pending frame is then granted at the permit point, counted from the end of the break.
- R7: A falling edge on rx while a lead is in progress cancels it. `drive_en` drops and no `tx_go` follows until a new permit point is reached.
- R8: When rx is received low for 10 or more bit times, `brk_flag` is set. It stays set until `brk_flag_clr` is asserted. Lows of 9 bit times or fewer do not set it, and neither does a break that this node sends itself.
- R9: A pulse on `sw_break` while the scheduler waits starts a break in the next cycle, and the break lasts 10 bit times.
- R10: A `cfg_load` pulse replaces the divider, the idle wait, the permit length, the maximum idle length and the lead. The new values govern all later timing. One bit time is `cfg_div`+1 clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx | input | 1 | Bus receive line, already synchronized |
| cfg_load | input | 1 | Loads all cfg_* values |
| cfg_div | input | 16 | Clocks per bit minus one |
| cfg_idle_wait | input | 8 | Bit times of high rx before idle |
| cfg_permit | input | 10 | Idle bit times until this node's permit point |
| cfg_max_idle | input | 10 | Idle bit times after which a break is used |
| cfg_lead | input | 2 | Bit times drive_en leads a granted frame |
| frame_pending | input | 1 | A frame is waiting to be sent |
| sw_break | input | 1 | Request a break character |
| brk_flag_clr | input | 1 | Clears brk_flag |
| bus_idle | output | 1 | Bus is idle |
| tx_go | output | 1 | One-cycle start grant to the transmitter |
| drive_en | output | 1 | Line driver enable during lead or break |
| line_low | output | 1 | Pulls the bus low (break) |
| brk_flag | output | 1 | Break received from another node |

## Verification
If the idle count or the bit phase holds a wrong value, the `tx_go` pulse and the edges of `bus_idle` land on the wrong bit boundary, a whole multiple of a bit period away. The bench measures these edge positions to the exact cycle against the last falling edge it caused. If the state machine is corrupted, it shows at the ports within one bit time: a break starts without cause, a grant goes missing, `drive_en` arrives without a lead, or a cancelled lead still produces a grant. Because the break counter is shared with the lead counter, a fault there shows directly as a wrong break length or lead length on `line_low` and `drive_en`.

// File: rtl/bs_pkg.sv
// Shared types and constants for the break-sync access scheduler.
package bs_pkg;
    // Access state: waiting for a slot, leading a grant, or sending a break.
    typedef enum logic [1:0] {
        ST_WAIT = 2'd0,
        ST_LEAD = 2'd1,
        ST_BRK  = 2'd2
    } bs_state_e;
endpackage

// File: rtl/bs_bit_timer.sv
// Bit-period timer. It produces a tick at the end of every bit period and
// realigns the phase to each falling edge of rx. It assumes rx has already
// been synchronized to clk.
module bs_bit_timer #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx,
    input  logic [DIV_W-1:0] div,
    output logic             fall,
    output logic             tick
);
    logic             rx_q;
    logic [DIV_W-1:0] phase;

    assign fall = rx_q & ~rx;
    assign tick = (phase == div) && !fall;

    // Previous rx sample, used for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) rx_q <= 1'b1;
        else        rx_q <= rx;
    end

    // Phase counter: restarts on a falling edge and wraps at the divider.
    always_ff @(posedge clk) begin
        if (!rst_n)             phase <= '0;
        else if (fall)          phase <= '0;
        else if (phase >= div)  phase <= '0;
        else                    phase <= phase + DIV_W'(1);
    end

    a_r10_phase_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        $past(fall) |-> (phase == '0));
endmodule

// File: rtl/bs_cfg_regs.sv
// Configuration holding registers. They take reset values from parameters
// and reload all fields together on a load strobe.
module bs_cfg_regs #(
    parameter int DIV_W      = 16,
    parameter int WAIT_W     = 8,
    parameter int LEN_W      = 10,
    parameter int LEAD_W     = 2,
    parameter int RST_DIV    = 346,
    parameter int RST_WAIT   = 10,
    parameter int RST_PERMIT = 20,
    parameter int RST_MAX    = 200,
    parameter int RST_LEAD   = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DIV_W-1:0]  in_div,
    input  logic [WAIT_W-1:0] in_wait,
    input  logic [LEN_W-1:0]  in_permit,
    input  logic [LEN_W-1:0]  in_max,
    input  logic [LEAD_W-1:0] in_lead,
    output logic [DIV_W-1:0]  div,
    output logic [WAIT_W-1:0] idle_wait,
    output logic [LEN_W-1:0]  permit,
    output logic [LEN_W-1:0]  max_idle,
    output logic [LEAD_W-1:0] lead
);
    // Reset to the defaults, otherwise capture every field on load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div       <= DIV_W'(RST_DIV);
            idle_wait <= WAIT_W'(RST_WAIT);
            permit    <= LEN_W'(RST_PERMIT);
            max_idle  <= LEN_W'(RST_MAX);
            lead      <= LEAD_W'(RST_LEAD);
        end else if (load) begin
            div       <= in_div;
            idle_wait <= in_wait;
            permit    <= in_permit;
            max_idle  <= in_max;
            lead      <= in_lead;
        end
    end
endmodule

// File: rtl/bs_line_monitor.sv
// Line monitor. It counts idle bit times while rx is high and low bit times
// while rx is low. It flags a received break when rx has been low for
// BRK_BITS bit times, except during this node's own break.
module bs_line_monitor #(
    parameter int WAIT_W   = 8,
    parameter int LEN_W    = 10,
    parameter int BRK_BITS = 10,
    localparam int CNT_W   = LEN_W + 1,
    localparam int LOW_W   = $clog2(BRK_BITS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx,
    input  logic              tick,
    input  logic [WAIT_W-1:0] idle_wait,
    input  logic              own_break,
    input  logic              flag_clr,
    output logic [CNT_W-1:0]  idle_cnt,
    output logic              bus_idle,
    output logic              brk_flag
);
    localparam logic [CNT_W-1:0] IDLE_SAT = '1;

    logic [LOW_W-1:0] low_cnt;
    logic             brk_hit;

    assign bus_idle = idle_cnt >= CNT_W'(idle_wait);
    assign brk_hit  = tick && !rx && !own_break && (low_cnt == LOW_W'(BRK_BITS - 1));

    // Idle counter: cleared by any low sample, saturates at its maximum.
    always_ff @(posedge clk) begin
        if (!rst_n)                         idle_cnt <= '0;
        else if (!rx)                       idle_cnt <= '0;
        else if (tick && idle_cnt != IDLE_SAT) idle_cnt <= idle_cnt + CNT_W'(1);
    end

    // Low-period counter: cleared by a high sample, saturates at BRK_BITS.
    always_ff @(posedge clk) begin
        if (!rst_n)                                   low_cnt <= '0;
        else if (rx)                                  low_cnt <= '0;
        else if (tick && low_cnt != LOW_W'(BRK_BITS)) low_cnt <= low_cnt + LOW_W'(1);
    end

    // Sticky break-received flag; a new detection wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)        brk_flag <= 1'b0;
        else if (brk_hit)  brk_flag <= 1'b1;
        else if (flag_clr) brk_flag <= 1'b0;
    end

    a_r2_idle_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx && idle_wait != '0) |=> !bus_idle);
    a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_flag && !flag_clr) |=> brk_flag);
    a_r8_no_self_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (own_break && !brk_flag) |=> !brk_flag);
endmodule

// File: rtl/bs_access_fsm.sv
// Access state machine. It grants a pending frame at the permit point, after
// an optional driver lead. It sends a break when a frame is pending past the
// maximum idle time, or when software asks for one. A falling edge on rx
// cancels a lead that has not yet produced a grant.
module bs_access_fsm
    import bs_pkg::*;
#(
    parameter int LEN_W    = 10,
    parameter int LEAD_W   = 2,
    parameter int BRK_BITS = 10,
    localparam int CNT_W   = LEN_W + 1,
    localparam int BC_W    = $clog2(BRK_BITS + (1 << LEAD_W))
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx,
    input  logic              tick,
    input  logic              fall,
    input  logic [CNT_W-1:0]  idle_cnt,
    input  logic [LEN_W-1:0]  permit,
    input  logic [LEN_W-1:0]  max_idle,
    input  logic [LEAD_W-1:0] lead,
    input  logic              pending,
    input  logic              sw_break,
    output logic              tx_go,
    output logic              drive_en,
    output logic              line_low
);
    localparam logic [CNT_W-1:0] IDLE_SAT = '1;

    bs_state_e       st, st_n;
    logic [BC_W-1:0] cnt, cnt_n;
    logic            go_n, sw_pend, sw_pend_n;
    logic            hit_permit, late;

    assign hit_permit = tick && rx && (idle_cnt != IDLE_SAT)
                        && ((idle_cnt + CNT_W'(1)) == CNT_W'(permit));
    assign late       = idle_cnt > CNT_W'(max_idle);

    // Next-state and grant decision.
    always_comb begin
        st_n  = st;
        cnt_n = cnt;
        go_n  = 1'b0;
        unique case (st)
            ST_WAIT: begin
                if (hit_permit && pending) begin
                    if (lead == '0) begin
                        go_n = 1'b1;
                    end else begin
                        st_n  = ST_LEAD;
                        cnt_n = '0;
                    end
                end else if ((late && pending) || sw_pend || sw_break) begin
                    st_n  = ST_BRK;
                    cnt_n = '0;
                end
            end
            ST_LEAD: begin
                if (fall) begin
                    st_n = ST_WAIT;
                end else if (tick) begin
                    if ((cnt + BC_W'(1)) == BC_W'(lead)) begin
                        go_n = 1'b1;
                        st_n = ST_WAIT;
                    end else begin
                        cnt_n = cnt + BC_W'(1);
                    end
                end
            end
            ST_BRK: begin
                if (tick) begin
                    if (cnt == BC_W'(BRK_BITS - 1)) st_n = ST_WAIT;
                    else                            cnt_n = cnt + BC_W'(1);
                end
            end
            default: st_n = ST_WAIT;
        endcase
        sw_pend_n = (sw_pend || sw_break) && !(st == ST_WAIT && st_n == ST_BRK);
    end

    // State, counter, software request latch and the registered grant pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_WAIT;
            cnt     <= '0;
            sw_pend <= 1'b0;
            tx_go   <= 1'b0;
        end else begin
            st      <= st_n;
            cnt     <= cnt_n;
            sw_pend <= sw_pend_n;
            tx_go   <= go_n;
        end
    end

    assign drive_en = (st == ST_LEAD) || (st == ST_BRK);
    assign line_low = (st == ST_BRK);

    a_r3_go_single: assert property (@(posedge clk) disable iff (!rst_n)
        tx_go |=> !tx_go);
    a_r4_lead_before_go: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_go && lead != '0) |-> $past(drive_en));
    a_r7_fall_cancels: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !tx_go);
    a_r6_brk_len: assert property (@(posedge clk) disable iff (!rst_n)
        line_low |-> (cnt < BC_W'(BRK_BITS)));
    a_r5_no_go_in_brk: assert property (@(posedge clk) disable iff (!rst_n)
        line_low |-> !tx_go);
endmodule

// File: rtl/bs_sched.sv
// Top of the break-sync access scheduler. It ties together the bit timer,
// the configuration registers, the line monitor and the access state machine.
// It assumes that rx is synchronized and that the transmitter starts its
// frame on tx_go.
module bs_sched #(
    parameter int DIV_W      = 16,
    parameter int WAIT_W     = 8,
    parameter int LEN_W      = 10,
    parameter int LEAD_W     = 2,
    parameter int BRK_BITS   = 10,
    parameter int RST_DIV    = 346,
    parameter int RST_WAIT   = 10,
    parameter int RST_PERMIT = 20,
    parameter int RST_MAX    = 200,
    parameter int RST_LEAD   = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx,
    input  logic              cfg_load,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic [WAIT_W-1:0] cfg_idle_wait,
    input  logic [LEN_W-1:0]  cfg_permit,
    input  logic [LEN_W-1:0]  cfg_max_idle,
    input  logic [LEAD_W-1:0] cfg_lead,
    input  logic              frame_pending,
    input  logic              sw_break,
    input  logic              brk_flag_clr,
    output logic              bus_idle,
    output logic              tx_go,
    output logic              drive_en,
    output logic              line_low,
    output logic              brk_flag
);
    localparam int CNT_W = LEN_W + 1;

    logic [DIV_W-1:0]  div;
    logic [WAIT_W-1:0] idle_wait;
    logic [LEN_W-1:0]  permit, max_idle;
    logic [LEAD_W-1:0] lead;
    logic              fall, tick;
    logic [CNT_W-1:0]  idle_cnt;

    bs_cfg_regs #(
        .DIV_W(DIV_W), .WAIT_W(WAIT_W), .LEN_W(LEN_W), .LEAD_W(LEAD_W),
        .RST_DIV(RST_DIV), .RST_WAIT(RST_WAIT), .RST_PERMIT(RST_PERMIT),
        .RST_MAX(RST_MAX), .RST_LEAD(RST_LEAD)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .load(cfg_load),
        .in_div(cfg_div), .in_wait(cfg_idle_wait), .in_permit(cfg_permit),
        .in_max(cfg_max_idle), .in_lead(cfg_lead),
        .div(div), .idle_wait(idle_wait), .permit(permit),
        .max_idle(max_idle), .lead(lead)
    );

    bs_bit_timer #(.DIV_W(DIV_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .rx(rx), .div(div),
        .fall(fall), .tick(tick)
    );

    bs_line_monitor #(.WAIT_W(WAIT_W), .LEN_W(LEN_W), .BRK_BITS(BRK_BITS)) u_mon (
        .clk(clk), .rst_n(rst_n), .rx(rx), .tick(tick), .idle_wait(idle_wait),
        .own_break(line_low), .flag_clr(brk_flag_clr),
        .idle_cnt(idle_cnt), .bus_idle(bus_idle), .brk_flag(brk_flag)
    );

    bs_access_fsm #(.LEN_W(LEN_W), .LEAD_W(LEAD_W), .BRK_BITS(BRK_BITS)) u_fsm (
        .clk(clk), .rst_n(rst_n), .rx(rx), .tick(tick), .fall(fall),
        .idle_cnt(idle_cnt), .permit(permit), .max_idle(max_idle), .lead(lead),
        .pending(frame_pending), .sw_break(sw_break),
        .tx_go(tx_go), .drive_en(drive_en), .line_low(line_low)
    );
endmodule

// File: tb/bs_sched_bench.sv
// Bench for bs_sched. It uses a 4-clock bit period and computes every
// expected edge from the falling edges it drives itself.
module bs_sched_bench;
    localparam int P = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ext = 1'b1;
    logic cfg_load = 1'b0;
    logic [15:0] cfg_div = '0;
    logic [7:0]  cfg_idle_wait = '0;
    logic [9:0]  cfg_permit = '0;
    logic [9:0]  cfg_max_idle = '0;
    logic [1:0]  cfg_lead = '0;
    logic frame_pending = 1'b0, sw_break = 1'b0, brk_flag_clr = 1'b0;
    logic bus_idle, tx_go, drive_en, line_low, brk_flag;
    logic rx;

    int ncyc = 0;
    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;
    always @(posedge clk) ncyc <= ncyc + 1;
    assign rx = ext & ~line_low;

    bs_sched #(.RST_DIV(P - 1)) u_bs_sched (
        .clk(clk), .rst_n(rst_n), .rx(rx), .cfg_load(cfg_load),
        .cfg_div(cfg_div), .cfg_idle_wait(cfg_idle_wait), .cfg_permit(cfg_permit),
        .cfg_max_idle(cfg_max_idle), .cfg_lead(cfg_lead),
        .frame_pending(frame_pending), .sw_break(sw_break),
        .brk_flag_clr(brk_flag_clr), .bus_idle(bus_idle), .tx_go(tx_go),
        .drive_en(drive_en), .line_low(line_low), .brk_flag(brk_flag)
    );

    task automatic chk(input string rq, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    task automatic finish_run;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    function automatic bit sig(input int sel);
        case (sel)
            0: return bus_idle;
            1: return tx_go;
            2: return drive_en;
            3: return line_low;
            4: return brk_flag;
            default: return !line_low;
        endcase
    endfunction

    task automatic wait_for(input int sel, output int at);
        at = -1;
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (sig(sel)) begin
                at = ncyc;
                break;
            end
        end
    endtask

    // Drive the other-node line low for a number of bit times.
    task automatic pulse_low(input int bits, input int sel, output int f,
                             output int first, output int gos);
        @(negedge clk);
        ext = 1'b0;
        f = ncyc + 1;
        first = -1;
        gos = 0;
        for (int i = 0; i < bits * P; i++) begin
            @(negedge clk);
            if (first < 0 && sig(sel)) first = ncyc;
            if (tx_go) gos++;
        end
        ext = 1'b1;
    endtask

    task automatic load(input int wt, input int pm, input int mx, input int ld);
        @(negedge clk);
        cfg_div = 16'(P - 1);
        cfg_idle_wait = 8'(wt);
        cfg_permit = 10'(pm);
        cfg_max_idle = 10'(mx);
        cfg_lead = 2'(ld);
        cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=0", ncyc);
        finish_run();
    end

    initial begin
        int f, r, at, first, gos, b1, x;
        repeat (5) @(negedge clk);
        chk("R1 tx_go reset", tx_go, 0);
        chk("R1 drive_en reset", drive_en, 0);
        chk("R1 line_low reset", line_low, 0);
        chk("R1 bus_idle reset", bus_idle, 0);
        chk("R1 brk_flag reset", brk_flag, 0);
        rst_n = 1'b1;

        // R1 defaults: wait 10, permit 20, lead 1.
        frame_pending = 1'b1;
        pulse_low(2, 1, f, first, gos);
        r = f + 2 * P;
        wait_for(0, at); chk("R2 idle edge defaults", at, r + 9 * P);
        wait_for(2, at); chk("R4 lead start defaults", at, r + 19 * P);
        wait_for(1, at); chk("R3 grant defaults", at, r + 20 * P);
        frame_pending = 1'b0;
        chk("R4 drive_en off at go", drive_en, 0);
        @(negedge clk); chk("R3 go one cycle", tx_go, 0);
        pulse_low(9, 4, f, first, gos);
        chk("R8 nine-bit low no flag", first, -1);

        // R10 / R3 / R4 sweep over permit and lead.
        for (int pm = 4; pm <= 8; pm++) begin
            for (int ld = 0; ld <= 3; ld++) begin
                load(3, pm, 12, ld);
                frame_pending = 1'b1;
                pulse_low(2, 1, f, first, gos);
                r = f + 2 * P;
                wait_for(0, at); chk("R10 idle wait loaded", at, r + 2 * P);
                if (ld > 0) begin
                    wait_for(2, at); chk("R4 lead start", at, r + (pm - 1) * P);
                end else begin
                    chk("R4 no drive without lead", drive_en, 0);
                end
                wait_for(1, at); chk("R3 grant time", at, r + (pm - 1 + ld) * P);
                frame_pending = 1'b0;
                pulse_low(9, 4, f, first, gos);
            end
        end

        // R5 / R6: frame pending only after the maximum idle time.
        load(3, 6, 12, 2);
        pulse_low(2, 1, f, first, gos);
        r = f + 2 * P;
        while (ncyc < r + 14 * P) @(negedge clk);
        chk("R5 no grant without pending", drive_en, 0);
        x = ncyc;
        frame_pending = 1'b1;
        wait_for(3, at); chk("R5 late break start", at, x + 1);
        chk("R5 break without lead", drive_en, 1);
        b1 = x + 2;
        wait_for(5, at); chk("R6 break length", at, b1 + 10 * P);
        wait_for(1, at); chk("R6 grant after break", at, b1 + 18 * P);
        frame_pending = 1'b0;
        chk("R8 own break no flag", brk_flag, 0);
        pulse_low(9, 4, f, first, gos);

        // R5: pending arrives between the permit point and the maximum.
        pulse_low(2, 1, f, first, gos);
        r = f + 2 * P;
        while (ncyc < r + 8 * P) @(negedge clk);
        frame_pending = 1'b1;
        wait_for(3, at); chk("R5 break at max crossing", at, r + 12 * P + 1);
        b1 = r + 12 * P + 2;
        wait_for(1, at); chk("R6 grant after crossing break", at, b1 + 18 * P);
        frame_pending = 1'b0;
        pulse_low(9, 4, f, first, gos);

        // R7: a falling edge cancels the lead.
        load(3, 6, 12, 3);
        frame_pending = 1'b1;
        pulse_low(2, 1, f, first, gos);
        r = f + 2 * P;
        wait_for(2, at); chk("R7 lead start", at, r + 5 * P);
        ext = 1'b0;
        f = ncyc + 1;
        @(negedge clk);
        chk("R7 drive_en dropped", drive_en, 0);
        chk("R2 idle dropped on low", bus_idle, 0);
        gos = tx_go ? 1 : 0;
        for (int i = 0; i < 9 * P - 1; i++) begin
            @(negedge clk);
            if (tx_go) gos++;
        end
        ext = 1'b1;
        chk("R7 no grant after cancel", gos, 0);
        r = f + 9 * P;
        wait_for(1, at); chk("R7 regrant", at, r + 8 * P);
        frame_pending = 1'b0;
        pulse_low(9, 4, f, first, gos);

        // R8: received break from another node.
        pulse_low(11, 4, f, first, gos);
        chk("R8 break flag time", first, f + 10 * P);
        @(negedge clk); chk("R8 flag held", brk_flag, 1);
        brk_flag_clr = 1'b1;
        @(negedge clk); brk_flag_clr = 1'b0;
        chk("R8 flag cleared", brk_flag, 0);

        // R9: software break.
        repeat (3) @(negedge clk);
        x = ncyc;
        sw_break = 1'b1;
        @(negedge clk); sw_break = 1'b0;
        chk("R9 sw break start", line_low, 1);
        b1 = x + 2;
        wait_for(5, at); chk("R9 sw break length", at, b1 + 10 * P);
        chk("R9 no flag from own break", brk_flag, 0);
        chk("R9 no grant", tx_go, 0);

        finish_run();
    end
endmodule